// File: doc/BRIEF.md
# Bidirectional Modulo-16 Counter

This block is a four-bit counter that steps upward, steps downward or holds, one step per clock edge, under the control of a two-line direction code. Inside it sits a plain loadable up counter. That counter has a synchronous clear, a parallel load, a count enable and a full-count flag.

Downward steps do not use a second adder path in the counter itself. A small piece of glue logic works out the value one below the present state, drives it onto the parallel inputs and asserts load. Upward steps use the counter's own enable.

Two flags report a wrap about to happen on the next edge: one for the upward wrap from 15 to 0, one for the downward wrap from 0 to 15. A synchronous clear returns the state to zero. The clear overrides whatever direction is requested.

Top module: `bidir_count16`

## Requirements
- R1: When `clr` is high at a rising clock edge, `cnt_q` becomes 0 after that edge, whatever the values on `dir_inc` and `dir_dec`.
- R2: With `clr` low, `dir_inc`=1 and `dir_dec`=0, each rising edge sets `cnt_q` to its previous value plus one.
- R3: With `clr` low, `dir_inc`=0 and `dir_dec`=1, each rising edge sets `cnt_q` to its previous value minus one.
- R4: Counting upward from 15 gives 0 on the next edge.
- R5: Counting downward from 0 gives 15 on the next edge.
- R6: With `clr` low and `dir_inc` equal to `dir_dec` (both 0 or both 1), `cnt_q` keeps its value across the edge.
- R7: `wrap_up` is 1 exactly when `cnt_q` is 15 and the code is upward (`dir_inc`=1, `dir_dec`=0). Otherwise it is 0. It is combinational from the present state and code.
- R8: `wrap_dn` is 1 exactly when `cnt_q` is 0 and the code is downward (`dir_inc`=0, `dir_dec`=1). Otherwise it is 0. It is combinational from the present state and code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear to zero, highest priority |
| dir_inc | input | 1 | Direction code line: 1 with `dir_dec`=0 means step up |
| dir_dec | input | 1 | Direction code line: 1 with `dir_inc`=0 means step down |
| cnt_q | output | 4 | Present counter state |
| wrap_up | output | 1 | Upward wrap on next edge (state 15, upward code) |
| wrap_dn | output | 1 | Downward wrap on next edge (state 0, downward code) |

## Verification
Once the first clear has been seen, the assertions check every cycle that the state moves by the amount the direction code asks for: plus one, minus one, or no change. They also check that both wrap boundaries land on the right value and that each flag matches the state and code. The clear's priority over a competing direction code, and the full walk through all sixteen values in each direction, are shown only by the bench's directed scenarios. Back-to-back changes of direction are covered by the bench's random sequences.

// File: rtl/bidir_count_pkg.sv
package bidir_count_pkg;

    localparam int unsigned CNT_W_DEF = 4;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_mode_e;

endpackage

// File: rtl/bidir_mode_decode.sv
module bidir_mode_decode
    import bidir_count_pkg::*;
(
    input  logic      inc_i,
    input  logic      dec_i,
    output dir_mode_e mode_o
);

    always_comb begin
        unique case ({inc_i, dec_i})
            2'b10:   mode_o = DIR_UP;
            2'b01:   mode_o = DIR_DOWN;
            default: mode_o = DIR_HOLD;
        endcase
    end

endmodule

// File: rtl/bidir_load_gen.sv
module bidir_load_gen
    import bidir_count_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF
) (
    input  dir_mode_e      mode_i,
    input  logic [W-1:0]   state_i,
    output logic           load_o,
    output logic           step_o,
    output logic [W-1:0]   pval_o,
    output logic           low_wrap_o
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] lower;

    // one below the present state, modulo 2**W
    assign lower = state_i + ALL_ONES;

    always_comb begin
        load_o     = 1'b0;
        step_o     = 1'b0;
        pval_o     = state_i;
        low_wrap_o = 1'b0;
        unique case (mode_i)
            DIR_UP: begin
                step_o = 1'b1;
            end
            DIR_DOWN: begin
                load_o     = 1'b1;
                pval_o     = lower;
                low_wrap_o = (state_i == '0);
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bidir_base_counter.sv
module bidir_base_counter #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         clr_i,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] pval_i,
    output logic [W-1:0] q_o,
    output logic         full_o
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (clr_i) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= pval_i;
        end else if (step_i) begin
            q_o <= q_o + 1'b1;
        end
    end

    assign full_o = step_i && (q_o == TOP_VAL);

endmodule

// File: rtl/bidir_count16.sv
module bidir_count16
    import bidir_count_pkg::*;
#(
    parameter int unsigned W = CNT_W_DEF
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         dir_inc,
    input  logic         dir_dec,
    output logic [W-1:0] cnt_q,
    output logic         wrap_up,
    output logic         wrap_dn
);

    dir_mode_e    mode;
    logic         ld;
    logic         en;
    logic [W-1:0] pval;

    bidir_mode_decode u_dec (
        .inc_i  (dir_inc),
        .dec_i  (dir_dec),
        .mode_o (mode)
    );

    bidir_load_gen #(.W(W)) u_glue (
        .mode_i     (mode),
        .state_i    (cnt_q),
        .load_o     (ld),
        .step_o     (en),
        .pval_o     (pval),
        .low_wrap_o (wrap_dn)
    );

    bidir_base_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .clr_i  (clr),
        .load_i (ld),
        .step_i (en),
        .pval_i (pval),
        .q_o    (cnt_q),
        .full_o (wrap_up)
    );

endmodule

// File: rtl/bidir_count16_chk.sv
module bidir_count16_chk #(
    parameter int unsigned W = 4
) (
    input logic         clk,
    input logic         clr,
    input logic         dir_inc,
    input logic         dir_dec,
    input logic [W-1:0] cnt_q,
    input logic         wrap_up,
    input logic         wrap_dn
);

    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (clr) armed <= 1'b1;
    end

    logic go_up, go_dn, stay;
    assign go_up = dir_inc && !dir_dec;
    assign go_dn = !dir_inc && dir_dec;
    assign stay  = (dir_inc == dir_dec);

    // R2
    a_r2_step_up: assert property (@(posedge clk) disable iff (clr)
        (armed && go_up) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

    // R3
    a_r3_step_down: assert property (@(posedge clk) disable iff (clr)
        (armed && go_dn) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

    // R4
    a_r4_top_wrap: assert property (@(posedge clk) disable iff (clr)
        (armed && go_up && cnt_q == TOP_VAL) |=> (cnt_q == '0));

    // R5
    a_r5_floor_wrap: assert property (@(posedge clk) disable iff (clr)
        (armed && go_dn && cnt_q == '0) |=> (cnt_q == TOP_VAL));

    // R6
    a_r6_hold: assert property (@(posedge clk) disable iff (clr)
        (armed && stay) |=> $stable(cnt_q));

    // R7
    a_r7_up_flag: assert property (@(posedge clk) disable iff (clr)
        armed |-> (wrap_up == (go_up && cnt_q == TOP_VAL)));

    // R8
    a_r8_down_flag: assert property (@(posedge clk) disable iff (clr)
        armed |-> (wrap_dn == (go_dn && cnt_q == '0)));

    // R7, R8: flags never both high
    a_r7_r8_exclusive: assert property (@(posedge clk) disable iff (clr)
        armed |-> !(wrap_up && wrap_dn));

endmodule

bind bidir_count16 bidir_count16_chk #(.W(W)) chk_i (
    .clk     (clk),
    .clr     (clr),
    .dir_inc (dir_inc),
    .dir_dec (dir_dec),
    .cnt_q   (cnt_q),
    .wrap_up (wrap_up),
    .wrap_dn (wrap_dn)
);

// File: tb/bidir_count16_tb_top.sv
`timescale 1ns/1ps
module bidir_count16_tb_top;

    logic       clk = 1'b0;
    logic       clr = 1'b0;
    logic       dir_inc = 1'b0;
    logic       dir_dec = 1'b0;
    logic [3:0] cnt_q;
    logic       wrap_up;
    logic       wrap_dn;

    int checks = 0;
    int errors = 0;
    logic [3:0] model = 4'd0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bidir_count16 dut_i (
        .clk     (clk),
        .clr     (clr),
        .dir_inc (dir_inc),
        .dir_dec (dir_dec),
        .cnt_q   (cnt_q),
        .wrap_up (wrap_up),
        .wrap_dn (wrap_dn)
    );

    function automatic logic [3:0] next_val(logic [3:0] s, logic c, logic i, logic d);
        if (c) return 4'd0;
        if (i && !d) return s + 4'd1;
        if (!i && d) return s - 4'd1;
        return s;
    endfunction

    function automatic logic exp_up(logic [3:0] s, logic i, logic d);
        return (s == 4'd15) && i && !d;
    endfunction

    function automatic logic exp_dn(logic [3:0] s, logic i, logic d);
        return (s == 4'd0) && !i && d;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string state_req(logic c, logic i, logic d, logic [3:0] s);
        if (c) return "R1";
        if (i && !d) return (s == 4'd15) ? "R4" : "R2";
        if (!i && d) return (s == 4'd0) ? "R5" : "R3";
        return "R6";
    endfunction

    // one clock step: drive at falling edge, check flags before the edge,
    // check state after it
    task automatic step(logic c, logic i, logic d);
        string rq;
        @(negedge clk);
        clr = c; dir_inc = i; dir_dec = d;
        #1;
        if (!c) begin
            check("R7", int'(wrap_up), int'(exp_up(model, i, d)));
            check("R8", int'(wrap_dn), int'(exp_dn(model, i, d)));
        end
        rq = state_req(c, i, d, model);
        model = next_val(model, c, i, d);
        @(posedge clk);
        #1;
        check(rq, int'(cnt_q), int'(model));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        // R1: reset state
        step(1'b1, 1'b0, 1'b0);
        check("R1", int'(cnt_q), 0);
        // R2, R4, R7: full upward lap
        for (int k = 0; k < 17; k++) step(1'b0, 1'b1, 1'b0);
        // R6: both hold codes
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b1, 1'b1);
        // R1 priority over upward code
        step(1'b1, 1'b1, 1'b0);
        // R3, R5, R8: full downward lap from 0
        for (int k = 0; k < 17; k++) step(1'b0, 1'b0, 1'b1);
        // R1 priority over downward code
        step(1'b1, 1'b0, 1'b1);
        // R6 at 0 and at 15
        step(1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1);
        step(1'b0, 1'b0, 1'b0);
        // random mixture
        for (int k = 0; k < 400; k++) begin
            logic [3:0] r;
            r = 4'($urandom);
            step(r == 4'd0, r[1], r[2]);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule